// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block keeps the operating mode of a double-data-rate SDRAM device and turns each READ or WRITE command into the column addresses of its burst. A mode-load command carries the settings on the address lines: burst length (2, 4, 8 beats or a whole page), beat ordering (sequential or interleaved) and read latency. Every later READ or WRITE with a start column and bank starts a burst. Because data moves on both strobe edges, the block gives two column addresses per clock, the even beat and the odd beat. A burst of N beats therefore takes N/2 clocks.

A memory model or controller uses the two column outputs to index its storage while a burst is running. The bank and direction come with them. Settings that the device cannot honour are flagged: a bad length code, an interleaved whole-page burst, or a latency other than the supported one. A whole-page burst that starts on an odd column is also flagged. A new READ or WRITE ends a running burst and restarts the sequencer, except that a READ may not cut a WRITE short.

Top module: `sdram_burst_agen`

## Requirements
- R1: After reset the block gives no beats, `mode_err` and `start_err` are low, `cfg_rd_lat` reads 3, and the mode is 2-beat sequential.
- R2: A mode-load command (`cmd_op`=01) sets the mode from `cmd_addr` one clock later. Bits [2:0] give the length code (001=2, 010=4, 011=8, 111=page), bit 3 gives the ordering (0 sequential, 1 interleaved) and bits [6:4] give the read latency, shown on `cfg_rd_lat`. `mode_err` goes high for any other length code, for page length with interleaved ordering, or for a latency other than 3.
- R3: An accepted READ (`cmd_op`=10) or WRITE (11) makes `beat_valid` high from the next clock on. Each clock carries beats 2i and 2i+1. A burst of N beats lasts exactly N/2 clocks.
- R4: In sequential ordering, the low log2(N) bits of beat k are the start column's low bits plus k, wrapping in that field; the upper column bits equal the start column's.
- R5: In interleaved ordering, the low log2(N) bits of beat k are the start column's low bits XOR k; the upper bits are kept.
- R6: A page burst runs over all 256 columns with wrap-around and continues until `burst_stop`. A `burst_stop` sampled high with no command ends any burst, so no beat is given the next clock.
- R7: A READ or WRITE in page mode with an odd start column is refused: no burst starts, and `start_err` is high for exactly the next clock.
- R8: A READ or WRITE during a burst ends it and restarts at the new column the next clock. The exception is a READ during a WRITE burst, which is ignored, and the WRITE burst runs to its end.
- R9: A mode-load command while a burst is running is ignored: the mode and `mode_err` stay unchanged.
- R10: While `mode_err` is high, READ and WRITE commands start no burst.
- R11: Every beat pair carries the bank (`beat_bank`) and direction (`beat_write`, 1 for WRITE) of the command that started the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this clock |
| cmd_op | input | 2 | 00 none, 01 mode load, 10 READ, 11 WRITE |
| cmd_addr | input | 8 | Start column, or the mode key in bits [6:0] |
| cmd_bank | input | 2 | Bank of a READ or WRITE |
| burst_stop | input | 1 | Ends the running burst |
| beat_valid | output | 1 | A beat pair is present |
| beat_col_even | output | 8 | Column of beat 2i |
| beat_col_odd | output | 8 | Column of beat 2i+1 |
| beat_bank | output | 2 | Bank of the running burst |
| beat_write | output | 1 | 1 when the running burst is a WRITE |
| cfg_rd_lat | output | 3 | Programmed read latency |
| mode_err | output | 1 | The mode held is not legal |
| start_err | output | 1 | Pulse: page burst refused on an odd column |

## Verification
Every result comes from a register loaded at the edge that samples the command. Mode fields, `mode_err` and `start_err` are therefore due one clock after the command, and the first beat pair shows in that same clock. Each further pair follows one clock later. The bench drives inputs on falling edges, and a monitor compares each beat pair against a queue filled by the driver, also on falling edges. Beats that are missing, reordered or extra show up at the exact clock they occur. A burst cut short by a command or by `burst_stop` adds to the queue only the pairs due before the cut.

// File: rtl/sbag_pkg.sv
package sbag_pkg;
    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_MRS   = 2'b01,
        OP_READ  = 2'b10,
        OP_WRITE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        BL_2    = 2'd0,
        BL_4    = 2'd1,
        BL_8    = 2'd2,
        BL_PAGE = 2'd3
    } blen_e;

    typedef struct packed {
        blen_e      blen;
        logic       ilv;
        logic [2:0] lat;
        logic       bad;
    } mode_t;
endpackage

// File: rtl/sbag_modereg.sv
module sbag_modereg
    import sbag_pkg::*;
#(
    parameter int LAT_OK = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [6:0] key,
    output mode_t      mode
);
    mode_t mode_d, mode_q;

    always_comb begin
        logic code_bad;
        mode_d   = mode_q;
        code_bad = 1'b0;
        if (load) begin
            case (key[2:0])
                3'b001:  mode_d.blen = BL_2;
                3'b010:  mode_d.blen = BL_4;
                3'b011:  mode_d.blen = BL_8;
                3'b111:  mode_d.blen = BL_PAGE;
                default: begin
                    mode_d.blen = BL_2;
                    code_bad    = 1'b1;
                end
            endcase
            mode_d.ilv = key[3];
            mode_d.lat = key[6:4];
            mode_d.bad = code_bad
                       || (key[2:0] == 3'b111 && key[3])
                       || (key[6:4] != 3'(LAT_OK));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '{blen: BL_2, ilv: 1'b0, lat: 3'(LAT_OK), bad: 1'b0};
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

    // R2: a mode held without the error flag never pairs page length with interleave
    a_r2_page_seq_only: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q.bad |-> !(mode_q.blen == BL_PAGE && mode_q.ilv));

    // R2: a legal mode always holds the supported latency
    a_r2_lat_legal: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q.bad |-> mode_q.lat == 3'(LAT_OK));
endmodule

// File: rtl/sbag_seq.sv
module sbag_seq
    import sbag_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int BEATS  = 2,
    localparam int CNT_W = COL_W - $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  op_e               cmd_op,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              burst_stop,
    input  blen_e             blen,
    input  logic              mode_bad,
    output logic              active,
    output logic [CNT_W-1:0]  pair_idx,
    output logic [COL_W-1:0]  start_col,
    output logic [BANK_W-1:0] bank,
    output logic              is_wr,
    output logic              start_err
);
    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [COL_W-1:0]  start;
        logic [BANK_W-1:0] bank;
        logic              wr;
        logic              serr;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] last_idx;
    logic             page;

    always_comb begin
        case (blen)
            BL_2:    last_idx = CNT_W'(0);
            BL_4:    last_idx = CNT_W'(1);
            BL_8:    last_idx = CNT_W'(3);
            default: last_idx = '1;
        endcase
    end

    assign page = (blen == BL_PAGE);

    always_comb begin
        logic is_rw, rd_on_wr, eligible, accept;
        is_rw    = cmd_valid && (cmd_op == OP_READ || cmd_op == OP_WRITE);
        rd_on_wr = st_q.active && st_q.wr && (cmd_op == OP_READ);
        eligible = is_rw && !mode_bad && !rd_on_wr;
        accept   = eligible && !(page && cmd_col[0]);

        st_d      = st_q;
        st_d.serr = eligible && page && cmd_col[0];
        if (accept) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.start  = cmd_col;
            st_d.bank   = cmd_bank;
            st_d.wr     = (cmd_op == OP_WRITE);
        end else if (st_q.active) begin
            if (burst_stop || (!page && st_q.cnt == last_idx)) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active    = st_q.active;
    assign pair_idx  = st_q.cnt;
    assign start_col = st_q.start;
    assign bank      = st_q.bank;
    assign is_wr     = st_q.wr;
    assign start_err = st_q.serr;

    // R7: a running page burst always began on an even column
    a_r7_page_even_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && page) |-> !st_q.start[0]);

    // R3: a finite burst never counts past its last pair
    a_r3_finite_span: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !page) |-> st_q.cnt <= last_idx);

    // R6: a stop with no command ends the burst by the next clock
    a_r6_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !cmd_valid) |=> !st_q.active);

    // R8: a read arriving during a write leaves the write running
    a_r8_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.wr && cmd_valid && cmd_op == OP_READ && !burst_stop
         && (page || st_q.cnt != last_idx))
        |=> (st_q.active && st_q.wr && $stable(st_q.start)));

    // R10: with an illegal mode an idle sequencer stays idle
    a_r10_bad_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bad && !st_q.active) |=> !st_q.active);
endmodule

// File: rtl/sbag_colcalc.sv
module sbag_colcalc
    import sbag_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int BEATS  = 2,
    localparam int CNT_W = COL_W - $clog2(BEATS)
) (
    input  logic [COL_W-1:0]            start_col,
    input  logic [CNT_W-1:0]            pair_idx,
    input  blen_e                       blen,
    input  logic                        ilv,
    output logic [BEATS-1:0][COL_W-1:0] cols
);
    logic [COL_W-1:0] mask;

    always_comb begin
        case (blen)
            BL_2:    mask = COL_W'(1);
            BL_4:    mask = COL_W'(3);
            BL_8:    mask = COL_W'(7);
            default: mask = '1;
        endcase
    end

    for (genvar g = 0; g < BEATS; g++) begin : g_lane
        logic [COL_W-1:0] beat_k, low;
        always_comb begin
            beat_k = COL_W'(pair_idx) * COL_W'(BEATS) + COL_W'(g);
            low    = ilv ? (start_col ^ beat_k) : (start_col + beat_k);
            cols[g] = (start_col & ~mask) | (low & mask);
        end
    end
endmodule

// File: rtl/sdram_burst_agen.sv
module sdram_burst_agen
    import sbag_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int LAT_OK = 3,
    localparam int BEATS = 2,
    localparam int CNT_W = COL_W - $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [COL_W-1:0]  cmd_addr,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              burst_stop,
    output logic              beat_valid,
    output logic [COL_W-1:0]  beat_col_even,
    output logic [COL_W-1:0]  beat_col_odd,
    output logic [BANK_W-1:0] beat_bank,
    output logic              beat_write,
    output logic [2:0]        cfg_rd_lat,
    output logic              mode_err,
    output logic              start_err
);
    op_e                       op;
    mode_t                     mode;
    logic                      busy;
    logic                      mrs_load;
    logic [CNT_W-1:0]          pair_idx;
    logic [COL_W-1:0]          start_col;
    logic [BEATS-1:0][COL_W-1:0] cols;

    assign op       = op_e'(cmd_op);
    assign mrs_load = cmd_valid && (op == OP_MRS) && !busy;

    sbag_modereg #(.LAT_OK(LAT_OK)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mrs_load),
        .key   (cmd_addr[6:0]),
        .mode  (mode)
    );

    sbag_seq #(.COL_W(COL_W), .BANK_W(BANK_W), .BEATS(BEATS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (op),
        .cmd_col    (cmd_addr),
        .cmd_bank   (cmd_bank),
        .burst_stop (burst_stop),
        .blen       (mode.blen),
        .mode_bad   (mode.bad),
        .active     (busy),
        .pair_idx   (pair_idx),
        .start_col  (start_col),
        .bank       (beat_bank),
        .is_wr      (beat_write),
        .start_err  (start_err)
    );

    sbag_colcalc #(.COL_W(COL_W), .BEATS(BEATS)) u_calc (
        .start_col (start_col),
        .pair_idx  (pair_idx),
        .blen      (mode.blen),
        .ilv       (mode.ilv),
        .cols      (cols)
    );

    assign beat_valid    = busy;
    assign beat_col_even = cols[0];
    assign beat_col_odd  = cols[1];
    assign cfg_rd_lat    = mode.lat;
    assign mode_err      = mode.bad;

    // R9: a mode load during a burst leaves the mode untouched
    a_r9_mrs_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid && op == OP_MRS) |=> $stable(mode));

    // R4: even and odd beats of a pair always differ only inside the burst field
    a_r4_pair_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> beat_col_even != beat_col_odd);
endmodule

// File: tb/sim_sdram_burst_agen.sv
`timescale 1ns/1ps
module sim_sdram_burst_agen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_addr = 8'h00;
    logic [1:0] cmd_bank = 2'b00;
    logic       burst_stop = 1'b0;
    logic       beat_valid, beat_write, mode_err, start_err;
    logic [7:0] beat_col_even, beat_col_odd;
    logic [1:0] beat_bank;
    logic [2:0] cfg_rd_lat;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;
    int cur_n = 2;
    bit cur_il = 0;

    typedef struct {
        logic [7:0] e;
        logic [7:0] o;
        logic [1:0] bank;
        logic       wr;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    sdram_burst_agen u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_bank(cmd_bank), .burst_stop(burst_stop),
        .beat_valid(beat_valid), .beat_col_even(beat_col_even),
        .beat_col_odd(beat_col_odd), .beat_bank(beat_bank),
        .beat_write(beat_write), .cfg_rd_lat(cfg_rd_lat),
        .mode_err(mode_err), .start_err(start_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ecol(input logic [7:0] s, input int k,
                                        input int n, input bit il);
        logic [7:0] m, low;
        m   = 8'(n - 1);
        low = il ? (s ^ 8'(k)) : (s + 8'(k));
        return (s & ~m) | (low & m);
    endfunction

    task automatic push(input logic [7:0] col, input logic [1:0] b,
                        input bit wr, input int np, input string req);
        for (int i = 0; i < np; i++) begin
            exp_t x;
            x.e = ecol(col, 2*i, cur_n, cur_il);
            x.o = ecol(col, 2*i+1, cur_n, cur_il);
            x.bank = b; x.wr = wr; x.req = req;
            sb.push_back(x);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [7:0] a, input logic [1:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_bank = b;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic mrs(input logic [2:0] code, input bit il, input logic [2:0] lat,
                       input bit exp_bad, input string req);
        send(2'b01, {1'b0, lat, il, code}, 2'b00);
        chk(mode_err == exp_bad, req, "mode_err", mode_err, exp_bad);
        chk(cfg_rd_lat == lat, req, "cfg_rd_lat", cfg_rd_lat, lat);
        if (!exp_bad) begin
            cur_il = il;
            cur_n  = (code == 3'b111) ? 256 : (1 << code);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && beat_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R3", "unexpected beat col", beat_col_even, 0);
            end else begin
                exp_t x;
                x = sb.pop_front();
                chk(beat_col_even == x.e, x.req, "even col", beat_col_even, x.e);
                chk(beat_col_odd == x.o, x.req, "odd col", beat_col_odd, x.o);
                chk(beat_bank == x.bank && beat_write == x.wr, "R11", "bank/dir",
                    {beat_bank, beat_write}, {x.bank, x.wr});
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(beat_valid == 0, "R1", "beat_valid", beat_valid, 0);
        chk(mode_err == 0 && start_err == 0, "R1", "errors", {mode_err, start_err}, 0);
        chk(cfg_rd_lat == 3, "R1", "cfg_rd_lat", cfg_rd_lat, 3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: default 2-beat sequential
        push(8'h13, 2'd0, 0, 1, "R1");
        send(2'b10, 8'h13, 2'd0);
        repeat (3) @(negedge clk);

        // R2 and R4: 4-beat sequential, wrap within the block
        mrs(3'b010, 0, 3'd3, 0, "R2");
        push(8'h06, 2'd1, 0, 2, "R4");
        send(2'b10, 8'h06, 2'd1);
        repeat (4) @(negedge clk);
        // R4: 8-beat sequential write
        mrs(3'b011, 0, 3'd3, 0, "R2");
        push(8'h1D, 2'd2, 1, 4, "R4");
        send(2'b11, 8'h1D, 2'd2);
        repeat (6) @(negedge clk);

        // R5 interleaved 8 and 4
        mrs(3'b011, 1, 3'd3, 0, "R2");
        push(8'h35, 2'd3, 0, 4, "R5");
        send(2'b10, 8'h35, 2'd3);
        repeat (6) @(negedge clk);
        mrs(3'b010, 1, 3'd3, 0, "R2");
        push(8'h4B, 2'd1, 1, 2, "R5");
        send(2'b11, 8'h4B, 2'd1);
        repeat (4) @(negedge clk);

        // R3: 2-beat burst from an odd column
        mrs(3'b001, 0, 3'd3, 0, "R2");
        push(8'h81, 2'd2, 0, 1, "R3");
        send(2'b10, 8'h81, 2'd2);
        repeat (3) @(negedge clk);

        // R6: page burst wraps at 256, stopped after 3 pairs
        mrs(3'b111, 0, 3'd3, 0, "R2");
        push(8'hFE, 2'd0, 0, 3, "R6");
        send(2'b10, 8'hFE, 2'd0);
        repeat (2) @(negedge clk);
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        chk(beat_valid == 0, "R6", "valid after stop", beat_valid, 0);
        repeat (2) @(negedge clk);

        // R7: odd page start refused
        send(2'b10, 8'h11, 2'd1);
        chk(start_err == 1, "R7", "start_err pulse", start_err, 1);
        chk(beat_valid == 0, "R7", "no burst", beat_valid, 0);
        @(negedge clk);
        chk(start_err == 0, "R7", "start_err one clock", start_err, 0);
        repeat (2) @(negedge clk);

        // R2 and R10: interleaved page is illegal, commands ignored
        mrs(3'b111, 1, 3'd3, 1, "R2");
        send(2'b10, 8'h10, 2'd0);
        chk(beat_valid == 0, "R10", "no burst in bad mode", beat_valid, 0);
        repeat (3) @(negedge clk);
        // R2: bad latency flagged, then repaired
        mrs(3'b010, 0, 3'd2, 1, "R2");
        mrs(3'b010, 0, 3'd3, 0, "R2");
        // R2: undefined length code
        mrs(3'b100, 0, 3'd3, 1, "R2");

        // R8: write interrupts read, read cannot interrupt write, read restarts read
        mrs(3'b011, 0, 3'd3, 0, "R2");
        push(8'h00, 2'd0, 0, 2, "R8");
        send(2'b10, 8'h00, 2'd0);
        push(8'h20, 2'd1, 1, 4, "R8");
        send(2'b11, 8'h20, 2'd1);
        send(2'b10, 8'h50, 2'd2);
        repeat (5) @(negedge clk);
        push(8'h60, 2'd3, 0, 2, "R8");
        send(2'b10, 8'h60, 2'd3);
        push(8'h70, 2'd2, 0, 4, "R8");
        send(2'b10, 8'h70, 2'd2);
        repeat (6) @(negedge clk);

        // R9: mode load during a burst ignored
        push(8'h08, 2'd1, 0, 4, "R9");
        send(2'b10, 8'h08, 2'd1);
        send(2'b01, 8'h21, 2'd0);
        chk(mode_err == 0, "R9", "mode_err kept", mode_err, 0);
        chk(cfg_rd_lat == 3, "R9", "latency kept", cfg_rd_lat, 3);
        repeat (6) @(negedge clk);

        chk(sb.size() == 0, "R3", "missing beats", sb.size(), 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule